// File: doc/BRIEF.md
# Three-Unit Phase-Shifted Triangular Carrier Modulator

This block turns one set of three-phase modulation references into gate commands for three cascaded two-level three-phase bridges. Each bridge unit has its own triangular carrier. The three carriers run at the same rate but are spread evenly in phase, with each unit trailing the one before it by a third of a carrier period. Every unit compares the same reference set against its own carrier. The result is three upper-switch commands per unit, nine in all. Each upper command also gets a complementary lower command, with a programmable blanking interval on every transition, so that the two switches of one leg are never on at the same time.

The references are taken in only at four fixed instants per carrier period. These instants follow the first unit's carrier. Between them, a reference that is still being rewritten cannot reach a comparator. The carrier half-period and the blanking length are run-time inputs. The reference computation and the control loop that feeds the block sit outside it.

Top module: `tri_carrier_pwm`

## Requirements
- R1: Each of the three carriers is an up/down count between 0 and P, where P is `half_period` (at least 3). It steps by one every clock, turns round at P and at 0, and repeats every 2P cycles.
- R2: At reset, unit 0's carrier is loaded to position 0 of its 2P-cycle cycle. Unit 1 is loaded to position 2P−D and unit 2 to position 2P−2D, where D = floor(2P/3), so unit k lags unit 0 by k·D cycles. A position q below P means a rising count of q; otherwise it means a falling count of 2P−q.
- R3: Upper command bit index is unit·3 + phase, with phases a, b, c numbered 0, 1, 2. That bit is 1 when the held reference of that phase, as a signed value, is strictly greater than 2·carrier − P. The result appears on `up_gate` two clocks after the carrier value it used.
- R4: The three references are captured at a clock edge only when unit 0's carrier stands at 0, at floor(P/2) or at P. floor(P/2) is reached twice, so this gives four captures per period. A change on the reference inputs at any other edge has no effect on the outputs.
- R5: With `dead_time` = 0, every `lo_gate` bit is the inverse of the matching `up_gate` bit.
- R6: No `up_gate` bit and its matching `lo_gate` bit are ever 1 in the same cycle.
- R7: With `dead_time` = N > 0, every change of an upper command holds both gates of that leg at 0 for exactly N cycles. After that, the new state is driven.
- R8: While `rst` is high, all `up_gate` bits are 0. All `lo_gate` bits are 1 if `dead_time` is 0 and 0 otherwise. The held references are cleared to 0.
- R9: A held reference of P+1 or above keeps that phase's upper command at 1 for every unit. A held reference of −P or below keeps it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the carrier phases |
| half_period | input | CAR_W | Carrier peak P; one carrier period is 2P clocks |
| dead_time | input | DT_W | Blanking cycles inserted on every gate transition |
| ref_a | input | CAR_W+1 | Signed reference, phase a |
| ref_b | input | CAR_W+1 | Signed reference, phase b |
| ref_c | input | CAR_W+1 | Signed reference, phase c |
| up_gate | output | 9 | Upper-switch commands, bit unit·3+phase |
| lo_gate | output | 9 | Lower-switch commands, same indexing |

## Verification
A reference captured at an edge reaches the comparators in the following cycle. The comparison is registered and then passes through the blanking stage. As a result, each gate reflects the carrier and held reference from two cycles earlier, and a blanking interval starts in the same cycle as the changed command. The bench samples on the falling clock edge. It carries its own expected comparisons through a two-stage delay line and keeps its own copy of the held references, which it updates only at the capture positions the requirements give. Blanking lengths are measured by counting consecutive both-low cycles on a leg, leaving out the settling period right after reset.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
    localparam int CAR_W     = 12;
    localparam int DT_W      = 8;
    localparam int NUM_UNITS = 3;
    localparam int NUM_PH    = 3;
    localparam int NUM_LEGS  = NUM_UNITS * NUM_PH;
    localparam int POS_W     = CAR_W + 2;

    typedef logic [CAR_W-1:0]        car_t;
    typedef logic signed [CAR_W:0]   ref_t;
    typedef logic [DT_W-1:0]         dt_t;
    typedef logic [POS_W-1:0]        pos_t;

    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

    typedef struct packed {
        car_t cnt;
        dir_e dir;
    } carrier_t;

    localparam pos_t THREE = pos_t'(3);

    // Starting state of unit idx: lag of idx thirds of a full period.
    function automatic carrier_t carrier_preload(car_t p, logic [1:0] idx);
        pos_t per;
        pos_t third;
        pos_t pos;
        carrier_t r;
        per   = {1'b0, p, 1'b0};
        third = per / THREE;
        pos   = (idx == 2'd0) ? '0 : per - (pos_t'(idx) * third);
        if (pos < {2'b00, p}) begin
            r.cnt = pos[CAR_W-1:0];
            r.dir = DIR_UP;
        end else begin
            r.cnt = CAR_W'(per - pos);
            r.dir = DIR_DOWN;
        end
        return r;
    endfunction

    // Signed threshold 2*cnt - p used by every comparator.
    function automatic logic signed [POS_W-1:0] carrier_level(car_t cnt, car_t p);
        return $signed({1'b0, cnt, 1'b0}) - $signed({2'b00, p});
    endfunction
endpackage

// File: rtl/tcp_carrier.sv
module tcp_carrier
    import tcp_pkg::*;
#(
    parameter int unsigned UNIT = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  car_t     half_period,
    output carrier_t st
);
    localparam logic [1:0] UNIT_IDX = 2'(UNIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= carrier_preload(half_period, UNIT_IDX);
        end else if (st.dir == DIR_UP) begin
            if (st.cnt >= half_period - 1'b1) begin
                st.cnt <= half_period;
                st.dir <= DIR_DOWN;
            end else begin
                st.cnt <= st.cnt + 1'b1;
            end
        end else begin
            if (st.cnt <= car_t'(1)) begin
                st.cnt <= '0;
                st.dir <= DIR_UP;
            end else begin
                st.cnt <= st.cnt - 1'b1;
            end
        end
    end

    // R1: unit step per clock while the period setting is steady
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!rst && $stable(half_period)) |=>
            ((st.cnt == $past(st.cnt) + 1'b1) || (st.cnt == $past(st.cnt) - 1'b1)));

    // R1: direction at the peak and at the floor
    p_peak_r1: assert property (@(posedge clk) disable iff (rst)
        (st.cnt == half_period) |-> (st.dir == DIR_DOWN));

    p_floor_r1: assert property (@(posedge clk) disable iff (rst)
        (st.cnt == '0) |-> (st.dir == DIR_UP));
endmodule

// File: rtl/tcp_refhold.sv
module tcp_refhold
    import tcp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  ref_t ref_in [NUM_PH],
    output ref_t ref_q  [NUM_PH]
);
    genvar ph;
    generate
        for (ph = 0; ph < NUM_PH; ph++) begin : g_ph
            always_ff @(posedge clk) begin
                if (rst)
                    ref_q[ph] <= '0;
                else if (upd)
                    ref_q[ph] <= ref_in[ph];
            end

            // R4: held value moves only after a capture instant
            p_hold_r4: assert property (@(posedge clk) disable iff (rst)
                (!rst && !upd) |=> $stable(ref_q[ph]));
        end
    endgenerate
endmodule

// File: rtl/tcp_deadtime.sv
module tcp_deadtime
    import tcp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dt_t  dead_time,
    input  logic cmd,
    output logic hi,
    output logic lo
);
    logic cur;
    dt_t  tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= 1'b0;
            tmr <= dead_time;
        end else if (cmd != cur) begin
            cur <= cmd;
            tmr <= dead_time;
        end else if (tmr != '0) begin
            tmr <= tmr - 1'b1;
        end
    end

    assign hi = cur  && (tmr == '0);
    assign lo = !cur && (tmr == '0);

    // R7: a newly raised switch follows a cycle where its partner was off
    p_rise_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (dead_time != '0 && $rose(hi)) |-> $past(!lo));

    p_lo_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (dead_time != '0 && $rose(lo)) |-> $past(!hi));
endmodule

// File: rtl/tri_carrier_pwm.sv
module tri_carrier_pwm
    import tcp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CAR_W-1:0]     half_period,
    input  logic [DT_W-1:0]      dead_time,
    input  logic signed [CAR_W:0] ref_a,
    input  logic signed [CAR_W:0] ref_b,
    input  logic signed [CAR_W:0] ref_c,
    output logic [NUM_LEGS-1:0]  up_gate,
    output logic [NUM_LEGS-1:0]  lo_gate
);
    carrier_t             car_st [NUM_UNITS];
    ref_t                 ref_in [NUM_PH];
    ref_t                 ref_q  [NUM_PH];
    logic                 upd;
    logic [NUM_LEGS-1:0]  up_cmd;

    assign ref_in[0] = ref_a;
    assign ref_in[1] = ref_b;
    assign ref_in[2] = ref_c;

    genvar u, ph;
    generate
        for (u = 0; u < NUM_UNITS; u++) begin : g_unit
            tcp_carrier #(.UNIT(u)) u_car (
                .clk         (clk),
                .rst         (rst),
                .half_period (half_period),
                .st          (car_st[u])
            );
        end
    endgenerate

    // Capture instants follow unit 0: floor, quarter points, peak.
    assign upd = (car_st[0].cnt == '0) ||
                 (car_st[0].cnt == half_period) ||
                 (car_st[0].cnt == (half_period >> 1));

    tcp_refhold u_hold (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .ref_in (ref_in),
        .ref_q  (ref_q)
    );

    generate
        for (u = 0; u < NUM_UNITS; u++) begin : g_cmp_u
            for (ph = 0; ph < NUM_PH; ph++) begin : g_cmp_p
                localparam int LEG = u * NUM_PH + ph;
                logic signed [POS_W-1:0] ref_ext;
                logic signed [POS_W-1:0] level;

                assign ref_ext = {ref_q[ph][CAR_W], ref_q[ph]};
                assign level   = carrier_level(car_st[u].cnt, half_period);

                always_ff @(posedge clk) begin
                    if (rst)
                        up_cmd[LEG] <= 1'b0;
                    else
                        up_cmd[LEG] <= (ref_ext > level);
                end

                tcp_deadtime u_dt (
                    .clk       (clk),
                    .rst       (rst),
                    .dead_time (dead_time),
                    .cmd       (up_cmd[LEG]),
                    .hi        (up_gate[LEG]),
                    .lo        (lo_gate[LEG])
                );
            end
        end
    endgenerate

    // R6: no leg has both switches commanded on
    p_no_shoot_r6: assert property (@(posedge clk) disable iff (rst)
        ((up_gate & lo_gate) == '0));

    // R5: without blanking the lower switch mirrors the upper one
    p_mirror_r5: assert property (@(posedge clk) disable iff (rst)
        (dead_time == '0) |-> (lo_gate == ~up_gate));
endmodule

// File: tb/tri_carrier_pwm_bench.sv
module tri_carrier_pwm_bench;
    import tcp_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst;
    car_t                hp;
    dt_t                 dt;
    ref_t                ra, rb, rc;
    logic [NUM_LEGS-1:0] ug, lg;

    int total = 0;
    int bad   = 0;
    int cyc;
    int pp;
    int mq [NUM_PH];
    logic [NUM_LEGS-1:0] d1, d2;

    localparam int NV = 12;
    localparam int VEC [NV][4] = '{
        '{0, 0, 0, 40},   '{6, -6, 0, 37},   '{13, -12, 3, 50},
        '{-3, 9, -9, 5},  '{2, 2, 2, 2},     '{-11, 11, 1, 3},
        '{5, -5, -1, 1},  '{8, -8, 4, 29},   '{12, -13, 0, 24},
        '{-1, 1, 7, 7},   '{0, 3, -3, 60},   '{10, -10, 0, 45}
    };

    tri_carrier_pwm u_tri_carrier_pwm (
        .clk(clk), .rst(rst), .half_period(hp), .dead_time(dt),
        .ref_a(ra), .ref_b(rb), .ref_c(rc), .up_gate(ug), .lo_gate(lg)
    );

    function automatic int carr(int pos, int p);
        return (pos < p) ? pos : 2 * p - pos;
    endfunction

    function automatic int prel(int k, int p);
        int t;
        t = 2 * p;
        return (k == 0) ? 0 : t - k * (t / 3);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic reset_dut(int p, int d);
        rst = 1'b1; hp = car_t'(p); dt = dt_t'(d);
        ra = '0; rb = '0; rc = '0;
        repeat (3) @(negedge clk);
        // R8: reset state of the gates
        check(ug == '0, "R8 upper", int'(ug), 0);
        check(lg == ((d == 0) ? '1 : '0), "R8 lower", int'(lg), (d == 0) ? 9'h1ff : 0);
        rst = 1'b0;
        pp = p; cyc = 0; d1 = '0; d2 = '0;
        for (int i = 0; i < NUM_PH; i++) mq[i] = 0;
    endtask

    // One cycle of the bench model: check, predict, drive, advance.
    task automatic step(int na, int nb, int nc, bit chk);
        logic [NUM_LEGS-1:0] cmp;
        int p0;
        if (chk) begin
            check(ug == d2, "R1 R2 R3 R4 upper", int'(ug), int'(d2));
            check(lg == ~d2, "R5 lower", int'(lg), int'(~d2));
        end
        for (int u = 0; u < NUM_UNITS; u++) begin
            int cv;
            cv = carr((prel(u, pp) + cyc) % (2 * pp), pp);
            for (int ph = 0; ph < NUM_PH; ph++)
                cmp[u * NUM_PH + ph] = (mq[ph] > 2 * cv - pp);
        end
        d2 = d1; d1 = cmp;
        ra = ref_t'(na); rb = ref_t'(nb); rc = ref_t'(nc);
        p0 = carr(cyc % (2 * pp), pp);
        if (p0 == 0 || p0 == pp || p0 == pp / 2) begin
            mq[0] = na; mq[1] = nb; mq[2] = nc;
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic run_table();
        for (int v = 0; v < NV; v++)
            for (int h = 0; h < VEC[v][3]; h++)
                step(VEC[v][0], VEC[v][1], VEC[v][2], 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Table with an even peak, then an odd peak
        reset_dut(12, 0);
        run_table();
        reset_dut(7, 0);
        run_table();

        // R9: saturated references
        reset_dut(12, 0);
        for (int i = 0; i < 60; i++) begin
            step(13, -12, 0, 1'b1);
            if (cyc >= 4) begin
                check((ug[0] & ug[3] & ug[6]) == 1'b1, "R9 high", int'(ug), 1);
                check((ug[1] | ug[4] | ug[7]) == 1'b0, "R9 low", int'(ug), 0);
            end
        end

        // R4: pulses on the input between capture instants are ignored
        reset_dut(12, 0);
        for (int i = 0; i < 30; i++) begin
            int a;
            a = (cyc >= 1 && cyc <= 5) ? 13 : -13;
            if (cyc >= 13 && cyc <= 17) a = 13;
            step(a, 0, 0, 1'b1);
            if (cyc >= 3)
                check((ug[0] | ug[3] | ug[6]) == 1'b0, "R4 ignored", int'(ug), 0);
        end

        // R6 R7: blanking of three cycles on every transition
        reset_dut(12, 3);
        begin
            int zrun;
            zrun = 0;
            for (int i = 0; i < 150; i++) begin
                check((ug & lg) == '0, "R6 overlap", int'(ug & lg), 0);
                if (!ug[0] && !lg[0]) begin
                    zrun++;
                end else begin
                    if (zrun > 0 && cyc > 10)
                        check(zrun == 3, "R7 gap", zrun, 3);
                    zrun = 0;
                end
                @(negedge clk);
                cyc++;
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule